// File: doc/BRIEF.md
# Parallel Pixel Capture Unit

This unit watches an 8-bit parallel input bus driven by a camera-style source and takes a sample on rising edges of its clock. A sample can be gated by two data-enable strobes that must both be high, or taken on every edge regardless of them. The stream of qualified samples can also be decimated so that only the even-numbered or only the odd-numbered ones survive. Surviving samples are gathered into a result of one, two or four bytes, first sample in the lowest byte, and the finished result is offered to a register reader together with a ready flag and a sticky overrun flag.

A six-bit configuration register sets up the unit. Bit 0 enables capture. Bit 1 makes sampling ignore the strobes. Bit 2 turns on decimation. Bit 3 picks the odd phase. Bits 5:4 select the result size. A write-protect input blocks every configuration write. Any accepted write, and any cycle with capture disabled, sends the sample index and the partial result back to their start.

Top module: `pcap_top`

## Requirements
- R1: After reset the configuration reads 0, `res_rdy` and `res_ovr` are 0 and `res_data` is 0.
- R2: While configuration bit 0 (enable) is 0, no sample is taken and `res_rdy` never rises.
- R3: With bit 1 (ignore strobes) at 0, a sample is qualified only on an edge where `pix_de_a` and `pix_de_b` are both 1.
- R4: With bit 1 at 1, a sample is qualified on every edge whatever the strobes show.
- R5: With bit 2 (decimate) at 0, every qualified sample is kept.
- R6: Qualified samples are numbered from 0. With bit 2 at 1, only the even-numbered ones are kept when bit 3 is 0, and only the odd-numbered ones when bit 3 is 1. Bit 3 has no effect while bit 2 is 0.
- R7: Size field bits 5:4 equal to 0, 1 or 2 complete a result after 1, 2 or 4 kept samples. The first kept sample sits in bits 7:0 and the upper bytes are zero for the smaller sizes. `res_data` is loaded on the edge of the last sample, and `res_rdy` rises one edge later.
- R8: Size field value 3 behaves as the 1-byte size.
- R9: A write with `cfg_wp` at 1 leaves the configuration unchanged.
- R10: A `res_rd` pulse clears `res_rdy` unless a new result completes in the same cycle.
- R11: A result that completes while `res_rdy` is 1 and not being read sets `res_ovr`. It stays set until a `stat_rd` pulse.
- R12: An accepted configuration write restarts the sample index and discards a partially gathered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, all state on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Write protect; blocks writes when 1 |
| cfg_wdata | input | 6 | Configuration write value |
| cfg_rdata | output | 6 | Current configuration |
| pix_d | input | 8 | Parallel sample bus |
| pix_de_a | input | 1 | First data-enable strobe |
| pix_de_b | input | 1 | Second data-enable strobe |
| res_rd | input | 1 | Result read pulse, clears ready |
| stat_rd | input | 1 | Status read pulse, clears overrun |
| res_data | output | 32 | Packed result |
| res_rdy | output | 1 | Result ready flag |
| res_ovr | output | 1 | Sticky overrun flag |

## Verification
A wrong decimation phase or a stale sample index shows up in `res_data` as bytes shifted by one position or swapped between neighbours. This appears on the first result after the fault, within at most four kept samples. A wrong lane counter or a missed restart mixes bytes from an abandoned capture into the next word, so that result is visibly corrupt. Flag faults appear on `res_rdy` and `res_ovr` one edge after the completing sample, and a missed clear persists until the next status read.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   // bit 0 enable, bit 1 ignore strobes, bit 2 decimate, bit 3 odd phase, bits 5:4 size
   typedef struct packed {
      size_e size;
      logic  odd;
      logic  half;
      logic  all;
      logic  en;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/pcap_cfg_reg.sv
module pcap_cfg_reg
   import pcap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             wp,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg,
   output logic             restart
);

   cfg_t cfg_q;
   logic wr_ok;

   assign wr_ok   = wr && !wp;
   assign restart = wr_ok || !cfg_q.en;
   assign cfg     = cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_ok) cfg_q <= cfg_t'(wdata);
   end

   assert_wp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wp) |=> $stable(cfg_q));

endmodule

// File: rtl/pcap_qualify.sv
module pcap_qualify #(
   parameter bit DECIM_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic en,
   input  logic all,
   input  logic half,
   input  logic odd,
   input  logic de_a,
   input  logic de_b,
   output logic keep
);

   logic qual;

   assign qual = !restart && en && (all || (de_a && de_b));

   generate
      if (DECIM_EN) begin : g_decim
         logic idx_odd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       idx_odd_q <= 1'b0;
            else if (restart) idx_odd_q <= 1'b0;
            else if (qual)    idx_odd_q <= !idx_odd_q;
         end

         assign keep = qual && (!half || (idx_odd_q == odd));

         assert_no_adjacent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (half && keep) |=> !keep);
      end else begin : g_plain
         assign keep = qual;
      end
   endgenerate

   assert_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (keep && !all) |-> (de_a && de_b));

   assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !keep);

   assert_every_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (all && en && !half && !restart) |-> keep);

endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
   import pcap_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    restart,
   input  logic                    keep,
   input  size_e                   size,
   input  logic [DATA_W-1:0]       din,
   output logic [DATA_W*LANES-1:0] result,
   output logic                    done
);

   localparam int OUT_W = DATA_W * LANES;
   localparam int CNT_W = $clog2(LANES + 1);

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("pcap_packer: LANES must be 4 for the size encoding");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pcap_packer: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] lane_q   [LANES];
   logic [DATA_W-1:0] asm_lane [LANES];
   logic [OUT_W-1:0]  asm_flat;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  need;
   logic              last;

   always_comb begin
      unique case (size)
         SZ_HALF: need = CNT_W'(2);
         SZ_WORD: need = CNT_W'(LANES);
         default: need = CNT_W'(1);
      endcase
   end

   assign last = keep && ((cnt_q + 1'b1) == need);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign asm_lane[l] = (CNT_W'(l) <  cnt_q) ? lane_q[l] :
                           (CNT_W'(l) == cnt_q) ? din       : '0;
      assign asm_flat[l*DATA_W +: DATA_W] = asm_lane[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         result <= '0;
         done   <= 1'b0;
         for (int l = 0; l < LANES; l++) lane_q[l] <= '0;
      end else begin
         done <= 1'b0;
         if (restart) begin
            cnt_q <= '0;
         end else if (keep) begin
            for (int l = 0; l < LANES; l++)
               if (cnt_q == CNT_W'(l)) lane_q[l] <= din;
            if (last) begin
               result <= asm_flat;
               cnt_q  <= '0;
               done   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < need);

   assert_rsvd_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (keep && size == SZ_RSVD) |=> done);

   assert_restart_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/pcap_flags.sv
module pcap_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic rd_res,
   input  logic rd_stat,
   output logic rdy,
   output logic ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy <= 1'b0;
         ovr <= 1'b0;
      end else begin
         if (done)        rdy <= 1'b1;
         else if (rd_res) rdy <= 1'b0;

         if (done && rdy && !rd_res) ovr <= 1'b1;
         else if (rd_stat)           ovr <= 1'b0;
      end
   end

   assert_rd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_res && !done) |=> !rdy);

   assert_ovr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rdy && !rd_res) |=> ovr);

   assert_ovr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !rd_stat) |=> ovr);

endmodule

// File: rtl/pcap_top.sv
module pcap_top
   import pcap_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LANES    = 4,
   parameter bit DECIM_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic                    cfg_wp,
   input  logic [CFG_W-1:0]        cfg_wdata,
   output logic [CFG_W-1:0]        cfg_rdata,
   input  logic [DATA_W-1:0]       pix_d,
   input  logic                    pix_de_a,
   input  logic                    pix_de_b,
   input  logic                    res_rd,
   input  logic                    stat_rd,
   output logic [DATA_W*LANES-1:0] res_data,
   output logic                    res_rdy,
   output logic                    res_ovr
);

   cfg_t cfg;
   logic restart;
   logic keep;
   logic done;

   assign cfg_rdata = cfg;

   pcap_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .wp      (cfg_wp),
      .wdata   (cfg_wdata),
      .cfg     (cfg),
      .restart (restart)
   );

   pcap_qualify #(.DECIM_EN(DECIM_EN)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .en      (cfg.en),
      .all     (cfg.all),
      .half    (cfg.half),
      .odd     (cfg.odd),
      .de_a    (pix_de_a),
      .de_b    (pix_de_b),
      .keep    (keep)
   );

   pcap_packer #(.DATA_W(DATA_W), .LANES(LANES)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .keep    (keep),
      .size    (cfg.size),
      .din     (pix_d),
      .result  (res_data),
      .done    (done)
   );

   pcap_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done),
      .rd_res  (res_rd),
      .rd_stat (stat_rd),
      .rdy     (res_rdy),
      .ovr     (res_ovr)
   );

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.en && !done) |=> !$rose(res_rdy));

endmodule

// File: tb/pcap_top_tb.sv
`timescale 1ns/1ps
module pcap_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_wp = 1'b0;
   logic [5:0]  cfg_wdata = '0;
   logic [5:0]  cfg_rdata;
   logic [7:0]  pix_d = '0;
   logic        pix_de_a = 1'b0;
   logic        pix_de_b = 1'b0;
   logic        res_rd = 1'b0;
   logic        stat_rd = 1'b0;
   logic [31:0] res_data;
   logic        res_rdy;
   logic        res_ovr;

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 1'b0;

   always #2 clk = !clk;

   pcap_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wp(cfg_wp),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_d(pix_d),
      .pix_de_a(pix_de_a), .pix_de_b(pix_de_b), .res_rd(res_rd),
      .stat_rd(stat_rd), .res_data(res_data), .res_rdy(res_rdy),
      .res_ovr(res_ovr)
   );

   // cfg bits: 0 en, 1 ignore strobes, 2 decimate, 3 odd, 5:4 size
   typedef struct packed {
      logic [5:0]  cfg;
      logic [7:0]  dea;
      logic [7:0]  deb;
      logic [31:0] res;
      logic        rdy;
      logic        ovr;
      logic [7:0]  tag;
   } vec_t;

   localparam int NV = 15;
   // samples are 8'h10 + i for i = 0..7
   localparam vec_t VECS [NV] = '{
      '{6'h01, 8'hFF, 8'hFF, 32'h00000017, 1'b1, 1'b1, 8'd5},
      '{6'h11, 8'hFF, 8'hFF, 32'h00001716, 1'b1, 1'b1, 8'd7},
      '{6'h21, 8'hFF, 8'hFF, 32'h17161514, 1'b1, 1'b1, 8'd7},
      '{6'h21, 8'hFF, 8'h0F, 32'h13121110, 1'b1, 1'b0, 8'd3},
      '{6'h21, 8'h55, 8'hFF, 32'h16141210, 1'b1, 1'b0, 8'd3},
      '{6'h23, 8'h00, 8'h00, 32'h17161514, 1'b1, 1'b1, 8'd4},
      '{6'h25, 8'hFF, 8'hFF, 32'h16141210, 1'b1, 1'b0, 8'd6},
      '{6'h2D, 8'hFF, 8'hFF, 32'h17151311, 1'b1, 1'b0, 8'd6},
      '{6'h09, 8'hFF, 8'hFF, 32'h00000017, 1'b1, 1'b1, 8'd6},
      '{6'h31, 8'hFF, 8'hFF, 32'h00000017, 1'b1, 1'b1, 8'd8},
      '{6'h00, 8'hFF, 8'hFF, 32'h00000000, 1'b0, 1'b0, 8'd2},
      '{6'h27, 8'h00, 8'h00, 32'h16141210, 1'b1, 1'b0, 8'd4},
      '{6'h21, 8'hF0, 8'hFF, 32'h17161514, 1'b1, 1'b0, 8'd3},
      '{6'h15, 8'hFF, 8'hFF, 32'h00001614, 1'b1, 1'b1, 8'd6},
      '{6'h1D, 8'h5A, 8'hFF, 32'h00001613, 1'b1, 1'b0, 8'd6}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [5:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic start_cfg(input logic [5:0] v);
      write_cfg(v & 6'h3E);
      res_rd = 1'b1;
      stat_rd = 1'b1;
      @(negedge clk);
      res_rd = 1'b0;
      stat_rd = 1'b0;
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic feed(input logic [7:0] d, input logic a, input logic b);
      pix_d = d;
      pix_de_a = a;
      pix_de_b = b;
      @(negedge clk);
   endtask

   task automatic stop_cap();
      pix_de_a = 1'b0;
      pix_de_b = 1'b0;
      write_cfg(6'h00);
   endtask

   task automatic run_vec(input vec_t v);
      start_cfg(v.cfg);
      for (int i = 0; i < 8; i++) feed(8'h10 + 8'(i), v.dea[i], v.deb[i]);
      stop_cap();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cfg", 32'(cfg_rdata), 32'h0);
      chk("R1 rdy", 32'(res_rdy), 32'h0);
      chk("R1 ovr", 32'(res_ovr), 32'h0);
      chk("R1 data", res_data, 32'h0);

      // R9: protected write is dropped, capture stays off (R2)
      cfg_wp = 1'b1;
      write_cfg(6'h23);
      chk("R9 cfg unchanged", 32'(cfg_rdata), 32'h0);
      for (int i = 0; i < 6; i++) feed(8'hE0 + 8'(i), 1'b1, 1'b1);
      chk("R2 no capture while off", 32'(res_rdy), 32'h0);
      cfg_wp = 1'b0;
      write_cfg(6'h22);
      chk("R9 unprotected write", 32'(cfg_rdata), 32'h22);

      // vector walk: R3 R4 R5 R6 R7 R8 R2 (tag lists the covered requirement)
      for (int k = 0; k < NV; k++) begin
         run_vec(VECS[k]);
         chk($sformatf("R%0d vec%0d rdy", VECS[k].tag, k), 32'(res_rdy), 32'(VECS[k].rdy));
         chk($sformatf("R11 vec%0d ovr", k), 32'(res_ovr), 32'(VECS[k].ovr));
         if (VECS[k].rdy)
            chk($sformatf("R%0d vec%0d data", VECS[k].tag, k), res_data, VECS[k].res);
      end

      // R10 / R11: read clears ready, overrun sticks until status read
      run_vec(VECS[0]);
      res_rd = 1'b1;
      @(negedge clk);
      res_rd = 1'b0;
      chk("R10 ready cleared", 32'(res_rdy), 32'h0);
      chk("R11 overrun held", 32'(res_ovr), 32'h1);
      repeat (2) @(negedge clk);
      chk("R11 overrun still held", 32'(res_ovr), 32'h1);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      chk("R11 overrun cleared", 32'(res_ovr), 32'h0);

      // R12: rewrite mid-word discards partial bytes
      start_cfg(6'h21);
      feed(8'hAA, 1'b1, 1'b1);
      feed(8'hBB, 1'b1, 1'b1);
      pix_de_a = 1'b0;
      pix_de_b = 1'b0;
      write_cfg(6'h21);
      for (int i = 0; i < 4; i++) feed(8'h20 + 8'(i), 1'b1, 1'b1);
      stop_cap();
      chk("R12 restart rdy", 32'(res_rdy), 32'h1);
      chk("R12 restart data", res_data, 32'h23222120);

      // R12 + R6: rewrite restarts index so even phase keeps first sample again
      start_cfg(6'h15);
      feed(8'h40, 1'b1, 1'b1);
      pix_de_a = 1'b0;
      pix_de_b = 1'b0;
      write_cfg(6'h15);
      for (int i = 0; i < 4; i++) feed(8'h50 + 8'(i), 1'b1, 1'b1);
      stop_cap();
      chk("R12 index restart data", res_data, 32'h00005250);

      finish_run();
   end

endmodule